// File: doc/BRIEF.md
# Operand Bypass and Pipeline Hazard Controller

This block is the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it reads the register numbers, the write enables and the load flag held in the stage registers, plus the branch decision that decode has already resolved. From these it chooses the source of each ALU operand in execute: the register file, the result held after execute, or the result held after the memory stage.

It also spots the one dependency that bypassing cannot cover. This happens when a load sits in execute and the instruction right behind it in decode reads the loaded register. In that case the block freezes the PC and the decode register for one cycle and turns the execute-stage entry into a bubble. A taken branch in decode throws away the instruction that was fetched behind it. If that same cycle also needs a load stall, the stall wins.

The register file writes in the first half of a cycle and reads in the second half. A write-back and a decode read of the same register therefore need no action from this block.

Top module: `hazard_ctrl`

## Requirements
- R1: Operand select codes are 2 bits: 2'b00 takes the register file, 2'b10 takes the post-execute result, 2'b01 takes the post-memory result; 2'b11 never appears.
- R2: An operand select (fwd_a for the execute rs, fwd_b for the execute rt) is 2'b10 when the post-execute stage writes (exmem_we high) a nonzero register equal to that source.
- R3: An operand select is 2'b01 when the post-memory stage writes a nonzero register equal to that source and the post-execute stage does not qualify for it.
- R4: When both later stages qualify for the same source, the post-execute result (2'b10) is chosen.
- R5: A stage whose write enable is low, or whose destination is register 0, never causes bypassing; the select is then 2'b00.
- R6: A stall (hold_pc high) is raised when idex_load is high, idex_rt is nonzero, and idex_rt equals ifid_rs or ifid_rt.
- R7: bubble_idex is high in exactly the cycles in which hold_pc is high.
- R8: A stall lasts one cycle: hold_pc is never high in two consecutive cycles, even if the load condition persists.
- R9: flush_if equals branch_taken when no stall is raised, and is low during a stall.
- R10: A post-memory destination equal to a decode-stage source causes no stall and no flush.
- R11: After reset, with idle inputs, all outputs are low and a stall may be raised in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ifid_rs | input | 5 | First source register of the instruction in decode |
| ifid_rt | input | 5 | Second source register of the instruction in decode |
| idex_rs | input | 5 | First source register of the instruction in execute |
| idex_rt | input | 5 | Second source of the instruction in execute; load destination |
| idex_load | input | 1 | Instruction in execute is a load |
| exmem_rd | input | 5 | Destination register after execute |
| exmem_we | input | 1 | Register write enable after execute |
| memwb_rd | input | 5 | Destination register after memory stage |
| memwb_we | input | 1 | Register write enable after memory stage |
| branch_taken | input | 1 | Branch in decode resolved as taken |
| fwd_a | output | 2 | Select code for ALU operand A |
| fwd_b | output | 2 | Select code for ALU operand B |
| hold_pc | output | 1 | Freeze PC and the decode register |
| bubble_idex | output | 1 | Clear the control bits entering execute |
| flush_if | output | 1 | Discard the instruction fetched behind a taken branch |

## Verification
The assertions assume the stage-register fields are driven with known values in every cycle after reset. They also assume branch_taken refers to an instruction already resolved in decode. The stimulus draws register numbers from a narrow range that includes register 0, so matches, double matches and zero-destination cases occur often. It also holds the load condition steady across several cycles so that the one-cycle stall limit is exercised.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_POSTMEM = 2'b01,
        SRC_POSTEX  = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic stalled;
    } hz_state_t;
endpackage

// File: rtl/bypass_pick.sv
module bypass_pick #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    sel
);
    import hazard_pkg::*;

    logic ex_hit;
    logic wb_hit;

    always_comb begin
        ex_hit = ex_we && (ex_rd != '0) && (ex_rd == src);
        wb_hit = wb_we && (wb_rd != '0) && (wb_rd == src);
        if (ex_hit)
            sel = SRC_POSTEX;
        else if (wb_hit)
            sel = SRC_POSTMEM;
        else
            sel = SRC_REGFILE;
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] dec_rs,
    input  logic [RW-1:0] dec_rt,
    input  logic [RW-1:0] ld_dst,
    input  logic          ld_valid,
    output logic          conflict
);
    always_comb begin
        conflict = ld_valid && (ld_dst != '0) &&
                   ((ld_dst == dec_rs) || (ld_dst == dec_rt));
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ifid_rs,
    input  logic [RW-1:0] ifid_rt,
    input  logic [RW-1:0] idex_rs,
    input  logic [RW-1:0] idex_rt,
    input  logic          idex_load,
    input  logic [RW-1:0] exmem_rd,
    input  logic          exmem_we,
    input  logic [RW-1:0] memwb_rd,
    input  logic          memwb_we,
    input  logic          branch_taken,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          hold_pc,
    output logic          bubble_idex,
    output logic          flush_if
);
    import hazard_pkg::*;

    localparam int NOPND = 2;

    hz_state_t st_d, st_q;
    logic [RW-1:0] opnd_src [NOPND];
    logic [1:0]    opnd_sel [NOPND];
    logic          conflict;

    assign opnd_src[0] = idex_rs;
    assign opnd_src[1] = idex_rt;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        bypass_pick #(.RW(RW)) u_pick (
            .src   (opnd_src[g]),
            .ex_rd (exmem_rd),
            .ex_we (exmem_we),
            .wb_rd (memwb_rd),
            .wb_we (memwb_we),
            .sel   (opnd_sel[g])
        );
    end

    load_use_detect #(.RW(RW)) u_lu (
        .dec_rs   (ifid_rs),
        .dec_rt   (ifid_rt),
        .ld_dst   (idex_rt),
        .ld_valid (idex_load),
        .conflict (conflict)
    );

    logic stall;

    always_comb begin
        st_d        = st_q;
        stall       = conflict && !st_q.stalled;
        st_d.stalled = stall;
        fwd_a       = opnd_sel[0];
        fwd_b       = opnd_sel[1];
        hold_pc     = stall;
        bubble_idex = stall;
        flush_if    = branch_taken && !stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

module hazard_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fwd_a,
    input logic [1:0] fwd_b,
    input logic       hold_pc,
    input logic       bubble_idex,
    input logic       flush_if,
    input logic       exmem_we,
    input logic       memwb_we,
    input logic       branch_taken
);
    // R1
    sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));
    // R5
    no_bypass_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exmem_we && !memwb_we) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));
    // R7
    hold_bubble_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_pc == bubble_idex);
    // R8
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_pc) && $past(rst_n)) |-> !hold_pc);
    // R9
    stall_beats_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_pc |-> !flush_if);
    // R9
    flush_follows_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_if |-> branch_taken);
endmodule

bind hazard_ctrl hazard_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fwd_a        (fwd_a),
    .fwd_b        (fwd_b),
    .hold_pc      (hold_pc),
    .bubble_idex  (bubble_idex),
    .flush_if     (flush_if),
    .exmem_we     (exmem_we),
    .memwb_we     (memwb_we),
    .branch_taken (branch_taken)
);

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] ifid_rs = '0, ifid_rt = '0, idex_rs = '0, idex_rt = '0;
    logic          idex_load = 1'b0;
    logic [RW-1:0] exmem_rd = '0, memwb_rd = '0;
    logic          exmem_we = 1'b0, memwb_we = 1'b0, branch_taken = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          hold_pc, bubble_idex, flush_if;

    int checks = 0;
    int failures = 0;
    logic exp_prev = 1'b0;
    logic exp_next = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    hazard_ctrl #(.RW(RW)) dut (.*);

    function automatic logic [1:0] ref_sel(logic [RW-1:0] s);
        if (exmem_we && exmem_rd != 0 && exmem_rd == s) return 2'b10;
        if (memwb_we && memwb_rd != 0 && memwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic ref_stall();
        return idex_load && idex_rt != 0 &&
               (idex_rt == ifid_rs || idex_rt == ifid_rt) && !exp_prev;
    endfunction

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic verify(string tag);
        logic st;
        st = ref_stall();
        #2;
        chk({tag, " fwd_a R2/R3/R4/R5"}, fwd_a, ref_sel(idex_rs));
        chk({tag, " fwd_b R2/R3/R4/R5"}, fwd_b, ref_sel(idex_rt));
        chk({tag, " hold R6/R8"}, {1'b0, hold_pc}, {1'b0, st});
        chk({tag, " bubble R7"}, {1'b0, bubble_idex}, {1'b0, st});
        chk({tag, " flush R9"}, {1'b0, flush_if}, {1'b0, branch_taken && !st});
        exp_next = st;
    endtask

    task automatic step_in();
        @(negedge clk);
        exp_prev = exp_next;
    endtask

    task automatic idle();
        ifid_rs = 0; ifid_rt = 0; idex_rs = 0; idex_rt = 0; idex_load = 0;
        exmem_rd = 0; exmem_we = 0; memwb_rd = 0; memwb_we = 0; branch_taken = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        idle();
        repeat (3) @(negedge clk);
        // R11: reset state, idle inputs
        #2;
        chk("reset hold R11", {1'b0, hold_pc}, 2'b00);
        chk("reset fwd R11", {fwd_a, fwd_b} == 4'b0 ? 2'b00 : 2'b11, 2'b00);
        rst_n = 1'b1;
        exp_prev = 0; exp_next = 0;

        // R11: stall allowed in first cycle after reset; R6
        step_in(); idle(); idex_load = 1; idex_rt = 5'd4; ifid_rs = 5'd4; verify("R11 first");
        // R8: condition persists, second cycle no stall
        step_in(); verify("R8 persist");
        step_in(); verify("R8 third");
        // R6 via rt match
        step_in(); idle(); verify("idle");
        step_in(); idex_load = 1; idex_rt = 5'd7; ifid_rt = 5'd7; verify("R6 rt");
        // R6: load to r0 never stalls
        step_in(); idle(); idex_load = 1; idex_rt = 0; verify("R6 zero");
        // R2
        step_in(); idle(); exmem_we = 1; exmem_rd = 5'd3; idex_rs = 5'd3; verify("R2 ex");
        // R3
        step_in(); idle(); memwb_we = 1; memwb_rd = 5'd9; idex_rt = 5'd9; verify("R3 wb");
        // R4
        step_in(); exmem_we = 1; exmem_rd = 5'd9; memwb_rd = 5'd9; idex_rs = 5'd9; verify("R4 both");
        // R5: we low and r0 destination
        step_in(); idle(); exmem_rd = 5'd2; idex_rs = 5'd2; memwb_we = 1; verify("R5 we low");
        step_in(); idle(); exmem_we = 1; memwb_we = 1; verify("R5 r0");
        // R9
        step_in(); idle(); branch_taken = 1; verify("R9 flush");
        step_in(); idex_load = 1; idex_rt = 5'd5; ifid_rs = 5'd5; verify("R9 stall wins");
        // R10
        step_in(); idle(); memwb_we = 1; memwb_rd = 5'd6; ifid_rs = 5'd6; ifid_rt = 5'd6; verify("R10");

        for (int i = 0; i < 2000; i++) begin
            step_in();
            if (($urandom % 4) != 0) begin
                ifid_rs = RW'($urandom % 4);
                ifid_rt = RW'($urandom % 4);
                idex_rs = RW'($urandom % 4);
                idex_rt = RW'($urandom % 4);
                idex_load = 1'($urandom);
            end
            exmem_rd = RW'($urandom % 4);
            memwb_rd = RW'($urandom % 4);
            exmem_we = 1'($urandom);
            memwb_we = 1'($urandom);
            branch_taken = 1'($urandom);
            verify("rand");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule